// File: doc/BRIEF.md
# Endpoint Service Interrupt Controller

This block keeps the service state of the eight physical endpoints of a full-speed USB device function. The packet side reports each completed transfer as a one-cycle strobe carrying a physical endpoint index and a byte count. The block then decides one of two outcomes. An endpoint the firmware has switched on is marked as needing service, and an oversized packet is flagged. An endpoint that is switched off gets a one-cycle refusal (NAK) pulse instead. The endpoint index sets the type: indices 0 and 1 are the control pair, 2 to 5 are the generic endpoints and 6 and 7 are the isochronous endpoints.

An embedded microcontroller sees one interrupt line, which is the OR of all pending bits. It uses a small register-mapped write/read bus to turn endpoints on or off, to read the pending and overflow masks and to clear them, and to see which half of the double-buffered isochronous endpoint (index 6) it owns. The packet side always uses the other half.

Top module: `usb_ep_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x03, the pending and overflow registers read 0x00, the buffer status register reads 0x02, and irq_o, nak_o and dbuf_pkt_half_o are 0.
- R2: Register address 0 is the enable mask, with bit n for endpoint n. Bits 7:2 take the written value. Bits 1:0 ignore writes and always read as 1.
- R3: A strobe on endpoint 0 or 1 is always accepted, even after a write of zero to the enable register. It sets the pending bit and never causes a NAK.
- R4: A strobe on an enabled endpoint sets bit n of the pending register (address 1) at the next clock edge. irq_o is high exactly when any pending bit is set.
- R5: A strobe on a disabled endpoint sets no pending bit, no overflow bit and does not swap the buffer half. nak_o is high for exactly the one cycle after the strobe.
- R6: Writing to address 1 clears each pending bit written as 1 and leaves the bits written as 0 unchanged.
- R7: If a strobe and a clear hit the same pending bit in the same cycle, the bit stays set. Other bits in the same clear are still cleared.
- R8: On an enabled endpoint, a byte count above the buffer size sets bit n of the overflow register (address 2). The buffer sizes are 16 for endpoints 0 and 1, 8 for endpoints 2 to 5, and 92 for endpoints 6 and 7. A count equal to the size does not set the bit. Writing 1 to a bit of address 2 clears it.
- R9: Each accepted strobe on endpoint 6 toggles the active half index, which starts at 0. dbuf_pkt_half_o equals the index and dbuf_cpu_half_o is its inverse. Address 3 reads {6'b0, cpu half, packet half}. Strobes on other endpoints leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid_i | input | 1 | One-cycle strobe marking a completed packet |
| pkt_ep_i | input | 3 | Physical endpoint index of the packet |
| pkt_len_i | input | 8 | Byte count of the packet |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 enable, 1 pending, 2 overflow, 3 buffer status) |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| irq_o | output | 1 | Service interrupt, the OR of the pending bits |
| nak_o | output | 1 | Pulse one cycle after a strobe to a disabled endpoint |
| dbuf_pkt_half_o | output | 1 | Half of endpoint 6 used by the packet side |
| dbuf_cpu_half_o | output | 1 | Half of endpoint 6 owned by the microcontroller |

## Verification
Two functions can fall in the same cycle: a packet strobe that sets a pending bit, and a firmware write-one-to-clear of that same bit. The bench provokes this by driving the strobe for endpoint 3 and a clear of bits 2 and 3 on the same falling edge, after both bits were set earlier. The result is judged at the next falling edge. Bit 3 must still read 1, bit 2 must read 0, and the interrupt must stay high.

// File: rtl/usb_ep_irq_pkg.sv
package usb_ep_irq_pkg;

    typedef enum logic [1:0] {
        REG_ENABLE = 2'd0,
        REG_PEND   = 2'd1,
        REG_OVF    = 2'd2,
        REG_DBUF   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/ep_w1c_bits.sv
module ep_w1c_bits #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);

    typedef struct packed {
        logic [N-1:0] bits;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // a new event overrides a same-cycle clear
        s_d.bits = (s_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bits_o = s_q.bits;

    for (genvar b = 0; b < N; b++) begin : g_chk
        // R7: a set in the same cycle as a clear still leaves the bit high
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> bits_o[b]);
        // R6: a clear without a set drops the bit
        a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !bits_o[b]);
    end

endmodule

// File: rtl/ep_event_decode.sv
module ep_event_decode #(
    parameter int NUM_EP     = 8,
    parameter int LEN_W      = 8,
    parameter int NUM_CTRL   = 2,
    parameter int NUM_GEN    = 4,
    parameter int CTRL_BYTES = 16,
    parameter int GEN_BYTES  = 8,
    parameter int ISO_BYTES  = 92,
    localparam int EP_W      = $clog2(NUM_EP)
) (
    input  logic              pkt_valid_i,
    input  logic [EP_W-1:0]   pkt_ep_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic [NUM_EP-1:0] en_mask_i,
    output logic [NUM_EP-1:0] accept_o,
    output logic [NUM_EP-1:0] ovf_o,
    output logic              nak_o
);

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        localparam int LIMIT = (e < NUM_CTRL)           ? CTRL_BYTES :
                               (e < NUM_CTRL + NUM_GEN) ? GEN_BYTES  : ISO_BYTES;
        logic hit;
        assign hit         = pkt_valid_i && (pkt_ep_i == EP_W'(e));
        assign accept_o[e] = hit && en_mask_i[e];
        assign ovf_o[e]    = accept_o[e] && (32'(pkt_len_i) > 32'(LIMIT));
    end

    assign nak_o = pkt_valid_i && !en_mask_i[pkt_ep_i];

    // R5: a refused packet is never also accepted
    always_comb begin
        a_r5_nak_excludes_accept: assert (!(nak_o && (accept_o != '0)));
    end

endmodule

// File: rtl/ep_dbuf_tracker.sv
module ep_dbuf_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle_i,
    output logic idx_o
);

    typedef struct packed {
        logic idx;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (toggle_i) s_d.idx = ~s_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx_o = s_q.idx;

    // R9: index flips on every accepted packet and holds otherwise
    a_r9_swap: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_i |=> (idx_o != $past(idx_o)));
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_i |=> $stable(idx_o));

endmodule

// File: rtl/usb_ep_irq_ctrl.sv
module usb_ep_irq_ctrl
    import usb_ep_irq_pkg::*;
#(
    parameter int NUM_EP     = 8,
    parameter int LEN_W      = 8,
    parameter int NUM_CTRL   = 2,
    parameter int NUM_GEN    = 4,
    parameter int CTRL_BYTES = 16,
    parameter int GEN_BYTES  = 8,
    parameter int ISO_BYTES  = 92,
    parameter int DBUF_EP    = 6,
    localparam int EP_W      = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid_i,
    input  logic [EP_W-1:0]   pkt_ep_i,
    input  logic [LEN_W-1:0]  pkt_len_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [NUM_EP-1:0] bus_wdata_i,
    output logic [NUM_EP-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              nak_o,
    output logic              dbuf_pkt_half_o,
    output logic              dbuf_cpu_half_o
);

    localparam logic [NUM_EP-1:0] CTRL_MASK = NUM_EP'((1 << NUM_CTRL) - 1);

    typedef struct packed {
        logic [NUM_EP-1:0] en;
        logic              nak;
    } state_t;

    state_t s_d, s_q;

    reg_sel_e          sel;
    logic [NUM_EP-1:0] accept, ovf_set, pend_clr, ovf_clr, pend, ovf;
    logic              nak_now, dbuf_idx;

    assign sel = reg_sel_e'(bus_addr_i);

    ep_event_decode #(
        .NUM_EP(NUM_EP), .LEN_W(LEN_W), .NUM_CTRL(NUM_CTRL), .NUM_GEN(NUM_GEN),
        .CTRL_BYTES(CTRL_BYTES), .GEN_BYTES(GEN_BYTES), .ISO_BYTES(ISO_BYTES)
    ) u_decode (
        .pkt_valid_i(pkt_valid_i), .pkt_ep_i(pkt_ep_i), .pkt_len_i(pkt_len_i),
        .en_mask_i(s_q.en), .accept_o(accept), .ovf_o(ovf_set), .nak_o(nak_now)
    );

    assign pend_clr = (bus_wr_i && sel == REG_PEND) ? bus_wdata_i : '0;
    assign ovf_clr  = (bus_wr_i && sel == REG_OVF)  ? bus_wdata_i : '0;

    ep_w1c_bits #(.N(NUM_EP)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(accept), .clr_i(pend_clr), .bits_o(pend)
    );

    ep_w1c_bits #(.N(NUM_EP)) u_ovf (
        .clk(clk), .rst_n(rst_n), .set_i(ovf_set), .clr_i(ovf_clr), .bits_o(ovf)
    );

    ep_dbuf_tracker u_dbuf (
        .clk(clk), .rst_n(rst_n), .toggle_i(accept[DBUF_EP]), .idx_o(dbuf_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.nak = nak_now;
        if (bus_wr_i && sel == REG_ENABLE) s_d.en = bus_wdata_i | CTRL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en  <= CTRL_MASK;
            s_q.nak <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (sel)
            REG_ENABLE: bus_rdata_o = s_q.en;
            REG_PEND:   bus_rdata_o = pend;
            REG_OVF:    bus_rdata_o = ovf;
            default:    bus_rdata_o = NUM_EP'({~dbuf_idx, dbuf_idx});
        endcase
    end

    assign irq_o           = |pend;
    assign nak_o           = s_q.nak;
    assign dbuf_pkt_half_o = dbuf_idx;
    assign dbuf_cpu_half_o = ~dbuf_idx;

    // R5: strobe on a disabled endpoint is refused on the next cycle
    a_r5_nak_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && !s_q.en[pkt_ep_i]) |=> nak_o);
    // R3: control endpoints are never refused
    a_r3_ctrl_never_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && pkt_ep_i < EP_W'(NUM_CTRL)) |=> !nak_o);
    // R4: an accepted packet raises the interrupt
    a_r4_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid_i && s_q.en[pkt_ep_i]) |=> irq_o);
    // R2: control enable bits always read back as set
    a_r2_ctrl_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_ENABLE) |-> (&bus_rdata_o[NUM_CTRL-1:0]));

endmodule

// File: tb/usb_ep_irq_ctrl_tb.sv
module usb_ep_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid_i = 1'b0;
    logic [2:0] pkt_ep_i = '0;
    logic [7:0] pkt_len_i = '0;
    logic       bus_wr_i = 1'b0;
    logic [1:0] bus_addr_i = '0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_o, nak_o, dbuf_pkt_half_o, dbuf_cpu_half_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_ep_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid_i(pkt_valid_i), .pkt_ep_i(pkt_ep_i), .pkt_len_i(pkt_len_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .nak_o(nak_o),
        .dbuf_pkt_half_o(dbuf_pkt_half_o), .dbuf_cpu_half_o(dbuf_cpu_half_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr_i = a;
        #1;
        d = bus_rdata_o;
    endtask

    task automatic check_reg(input string req, input logic [1:0] a, input int exp);
        logic [7:0] d;
        rd(a, d);
        check(req, int'(d), exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0; bus_wdata_i = '0;
        #1;
    endtask

    task automatic pkt(input int ep, input int len);
        pkt_valid_i = 1'b1; pkt_ep_i = 3'(ep); pkt_len_i = 8'(len);
        @(negedge clk);
        pkt_valid_i = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        check_reg("R1 enable", 2'd0, 8'h03);
        check_reg("R1 pending", 2'd1, 8'h00);
        check_reg("R1 overflow", 2'd2, 8'h00);
        check_reg("R1 dbuf", 2'd3, 8'h02);
        check("R1 irq", int'(irq_o), 0);
        check("R1 nak", int'(nak_o), 0);
        check("R1 pkt half", int'(dbuf_pkt_half_o), 0);
    endtask

    task automatic t_enable;
        wr(2'd0, 8'h00); check_reg("R2 zero write", 2'd0, 8'h03);
        wr(2'd0, 8'hFC); check_reg("R2 all write", 2'd0, 8'hFF);
        wr(2'd0, 8'h50); check_reg("R2 pattern", 2'd0, 8'h53);
    endtask

    task automatic t_ctrl;
        wr(2'd0, 8'h00);
        pkt(0, 4);
        check("R3 ep0 no nak", int'(nak_o), 0);
        check_reg("R3 ep0 pending", 2'd1, 8'h01);
        check("R4 irq on", int'(irq_o), 1);
        pkt(1, 16);
        check("R3 ep1 no nak", int'(nak_o), 0);
        check_reg("R3 ep1 pending", 2'd1, 8'h03);
        wr(2'd1, 8'h03);
        check_reg("R6 cleared", 2'd1, 8'h00);
        check("R4 irq off", int'(irq_o), 0);
    endtask

    task automatic t_nak;
        pkt(5, 2);
        check("R5 nak pulse", int'(nak_o), 1);
        check_reg("R5 no pending", 2'd1, 8'h00);
        check("R5 no irq", int'(irq_o), 0);
        @(negedge clk); #1;
        check("R5 nak one cycle", int'(nak_o), 0);
        pkt(6, 100);
        check("R5 ep6 nak", int'(nak_o), 1);
        check_reg("R5 no swap", 2'd3, 8'h02);
        check_reg("R5 no overflow", 2'd2, 8'h00);
    endtask

    task automatic t_pend;
        wr(2'd0, 8'hFF);
        pkt(3, 8);
        check("R4 ep3 no nak", int'(nak_o), 0);
        check_reg("R4 ep3 pending", 2'd1, 8'h08);
        check("R4 irq", int'(irq_o), 1);
        check_reg("R8 equal size no overflow", 2'd2, 8'h00);
        pkt(7, 5);
        check_reg("R4 ep7 pending", 2'd1, 8'h88);
    endtask

    task automatic t_w1c;
        wr(2'd1, 8'h80); check_reg("R6 partial clear", 2'd1, 8'h08);
        wr(2'd1, 8'h00); check_reg("R6 zero write", 2'd1, 8'h08);
        wr(2'd1, 8'h08); check_reg("R6 final clear", 2'd1, 8'h00);
        check("R6 irq low", int'(irq_o), 0);
    endtask

    task automatic t_collide;
        pkt(2, 1);
        pkt(3, 1);
        check_reg("R7 setup", 2'd1, 8'h0C);
        pkt_valid_i = 1'b1; pkt_ep_i = 3'd3; pkt_len_i = 8'd1;
        bus_wr_i = 1'b1; bus_addr_i = 2'd1; bus_wdata_i = 8'h0C;
        @(negedge clk);
        pkt_valid_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
        #1;
        check_reg("R7 set wins", 2'd1, 8'h08);
        check("R7 irq held", int'(irq_o), 1);
        wr(2'd1, 8'hFF);
    endtask

    task automatic t_ovf;
        pkt(0, 17); check_reg("R8 ctrl over", 2'd2, 8'h01);
        pkt(1, 16); check_reg("R8 ctrl equal", 2'd2, 8'h01);
        pkt(4, 9);  check_reg("R8 generic over", 2'd2, 8'h11);
        pkt(5, 8);  check_reg("R8 generic equal", 2'd2, 8'h11);
        pkt(6, 93); check_reg("R8 iso over", 2'd2, 8'h51);
        pkt(6, 92); check_reg("R8 iso equal", 2'd2, 8'h51);
        pkt(7, 200); check_reg("R8 ep7 over", 2'd2, 8'hD1);
        wr(2'd2, 8'h10); check_reg("R8 partial clear", 2'd2, 8'hC1);
        wr(2'd2, 8'hFF); check_reg("R8 full clear", 2'd2, 8'h00);
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hEF);
        pkt(4, 50);
        check("R5 disabled over nak", int'(nak_o), 1);
        check_reg("R5 disabled no overflow", 2'd2, 8'h00);
        check_reg("R5 disabled no pending", 2'd1, 8'h00);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_dbuf;
        check_reg("R9 start", 2'd3, 8'h02);
        pkt(6, 10);
        check_reg("R9 first swap", 2'd3, 8'h01);
        check("R9 pkt half", int'(dbuf_pkt_half_o), 1);
        check("R9 cpu half", int'(dbuf_cpu_half_o), 0);
        pkt(7, 10);
        check_reg("R9 ep7 no swap", 2'd3, 8'h01);
        pkt(6, 10);
        check_reg("R9 second swap", 2'd3, 8'h02);
        wr(2'd0, 8'hBF);
        pkt(6, 10);
        check_reg("R9 disabled no swap", 2'd3, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_enable();
        t_ctrl();
        t_nak();
        t_pend();
        t_w1c();
        t_collide();
        t_ovf();
        t_dbuf();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule